// File: doc/BRIEF.md
# Trap Vector and Return Sequencer

This block serves the trap-entry and trap-return instructions of a small processor core. For a software trap it adds a base operand and an offset operand, keeps the low seven bits of the sum and places them in the upper half of the vector space, so every software trap lands on a number from 128 to 255. For a return-from-trap it inspects the supervisor bit, the trap-enable bit, the debug-mode flag and the instruction's debug field, and then selects the next program counter. It also produces the status write-back and the request to leave debug mode.

A request is a one-cycle `start_i` pulse together with the operation select and the operands. One cycle later every result appears on registered outputs, with a `done_o` strobe. The halt, illegal, trap, write-enable and debug-exit outputs are one-cycle pulses that coincide with `done_o`. The next PC and the status values hold until the next request. The trap number holds until the next trap request.

Top module: `trapret_unit`

## Requirements
- R1: A trap request (`op_ret_i`=0) yields `trap_num_o` = ((base+offset) & 0x7F) + 0x80, a `trap_req_o` pulse and `next_pc_o` = PC+4. It raises no halt, illegal or write-back pulse.
- R2: A return with S=0 and ET=0 raises `halt_o`, gives `next_pc_o` = PC+4 and asserts no `stat_we_o`.
- R3: A return with S=0 and ET=1 raises neither halt nor illegal, gives PC+4 and asserts no write-back.
- R4: A return with S=1 and ET=1 raises `illegal_o`, gives PC+4 and asserts no write-back.
- R5: A return with S=1, ET=0, debug mode off and debug field 0 gives `next_pc_o` = saved PC and `stat_we_o`=1, with `stat_et_o`=1 and `stat_s_o`=PS.
- R6: A return with S=1, ET=0, debug mode on and debug field 1 gives `next_pc_o` = debug saved PC and `stat_we_o`=1, with ET and S taken from the debug saved bits, and pulses `dbg_exit_o`.
- R7: A return with S=1 and ET=0 in which debug mode and debug field disagree gives PC+4, no write-back and no pulses. In that case `stat_s_o` and `stat_et_o` equal the incoming S and ET.
- R8: The cases are tested in this order: S clear first, then ET set, then the normal return, then the debug return. A return that also meets the debug-return condition follows the first case that matches.
- R9: All outputs and `done_o` change in the cycle after `start_i`. The pulse outputs drop in the next cycle that has no start.
- R10: After reset, all outputs are 0.
- R11: A return request leaves `trap_num_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse |
| op_ret_i | input | 1 | 1 = return-from-trap, 0 = software trap |
| base_i | input | 32 | Trap base operand |
| offset_i | input | 32 | Trap offset operand |
| pc_i | input | 32 | Current PC |
| stat_s_i | input | 1 | Supervisor bit |
| stat_et_i | input | 1 | Trap-enable bit |
| stat_ps_i | input | 1 | Previous-supervisor bit |
| saved_pc_i | input | 32 | Saved PC for normal return |
| dbg_saved_pc_i | input | 32 | Saved PC for debug return |
| dbg_saved_et_i | input | 1 | Saved trap-enable for debug return |
| dbg_saved_s_i | input | 1 | Saved supervisor for debug return |
| dbg_mode_i | input | 1 | Core is in debug mode |
| dbg_field_i | input | 1 | Debug field of the return instruction |
| done_o | output | 1 | Results valid strobe |
| next_pc_o | output | 32 | Selected next PC |
| trap_num_o | output | 8 | Trap vector number |
| trap_req_o | output | 1 | Trap request pulse |
| halt_o | output | 1 | Halt request pulse |
| illegal_o | output | 1 | Illegal-instruction request pulse |
| stat_we_o | output | 1 | Status write-back enable pulse |
| stat_s_o | output | 1 | Status S write-back value |
| stat_et_o | output | 1 | Status ET write-back value |
| dbg_exit_o | output | 1 | Leave-debug-mode pulse |

## Verification
Two functions can coincide in one cycle: the status write-back and the exit from debug mode. Both fire on a debug return. The bench provokes this with S=1, ET=0 and both debug inputs set. It then confirms that `stat_we_o` and `dbg_exit_o` rise in the same cycle, with the debug saved bits on the status outputs. The bench also sets the debug-return inputs while S is clear or ET is set. In those cases the earlier case must win, so neither pulse may appear.

// File: rtl/trapret_pkg.sv
package trapret_pkg;
  typedef enum logic [2:0] {
    RC_HALT_CHK  = 3'd0,
    RC_PRIV_SKIP = 3'd1,
    RC_ILLEGAL   = 3'd2,
    RC_NORMAL    = 3'd3,
    RC_DEBUG     = 3'd4,
    RC_NOP       = 3'd5
  } ret_case_e;
endpackage

// File: rtl/trapret_vecgen.sv
module trapret_vecgen #(
  parameter int XLEN   = 32,
  parameter int TNUM_W = 8
) (
  input  logic [XLEN-1:0]   base_i,
  input  logic [XLEN-1:0]   offset_i,
  output logic [TNUM_W-1:0] num_o
);
  localparam int LOW_W = TNUM_W - 1;
  logic [XLEN-1:0] sum;
  always_comb begin
    sum   = base_i + offset_i;
    num_o = {1'b1, sum[LOW_W-1:0]};
  end
endmodule

// File: rtl/trapret_decide.sv
module trapret_decide
  import trapret_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic            s_i,
  input  logic            et_i,
  input  logic            ps_i,
  input  logic [XLEN-1:0] saved_pc_i,
  input  logic [XLEN-1:0] dbg_saved_pc_i,
  input  logic            dbg_saved_et_i,
  input  logic            dbg_saved_s_i,
  input  logic            dbg_mode_i,
  input  logic            dbg_field_i,
  output ret_case_e       case_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic            s_o,
  output logic            et_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  always_comb begin
    if (!s_i)
      case_o = et_i ? RC_PRIV_SKIP : RC_HALT_CHK;
    else if (et_i)
      case_o = RC_ILLEGAL;
    else if (!dbg_mode_i && !dbg_field_i)
      case_o = RC_NORMAL;
    else if (dbg_mode_i && dbg_field_i)
      case_o = RC_DEBUG;
    else
      case_o = RC_NOP;
  end

  always_comb begin
    next_pc_o = pc_i + STEP;
    s_o       = s_i;
    et_o      = et_i;
    unique case (case_o)
      RC_NORMAL: begin
        next_pc_o = saved_pc_i;
        s_o       = ps_i;
        et_o      = 1'b1;
      end
      RC_DEBUG: begin
        next_pc_o = dbg_saved_pc_i;
        s_o       = dbg_saved_s_i;
        et_o      = dbg_saved_et_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trapret_unit.sv
module trapret_unit
  import trapret_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int TNUM_W     = 8,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_ret_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic [XLEN-1:0]   offset_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              stat_s_i,
  input  logic              stat_et_i,
  input  logic              stat_ps_i,
  input  logic [XLEN-1:0]   saved_pc_i,
  input  logic [XLEN-1:0]   dbg_saved_pc_i,
  input  logic              dbg_saved_et_i,
  input  logic              dbg_saved_s_i,
  input  logic              dbg_mode_i,
  input  logic              dbg_field_i,
  output logic              done_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic [TNUM_W-1:0] trap_num_o,
  output logic              trap_req_o,
  output logic              halt_o,
  output logic              illegal_o,
  output logic              stat_we_o,
  output logic              stat_s_o,
  output logic              stat_et_o,
  output logic              dbg_exit_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [TNUM_W-1:0] vec_num;
  ret_case_e         rcase;
  logic [XLEN-1:0]   ret_pc;
  logic              ret_s, ret_et;

  trapret_vecgen #(.XLEN(XLEN), .TNUM_W(TNUM_W)) u_vec (
    .base_i  (base_i),
    .offset_i(offset_i),
    .num_o   (vec_num)
  );

  trapret_decide #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_dec (
    .pc_i          (pc_i),
    .s_i           (stat_s_i),
    .et_i          (stat_et_i),
    .ps_i          (stat_ps_i),
    .saved_pc_i    (saved_pc_i),
    .dbg_saved_pc_i(dbg_saved_pc_i),
    .dbg_saved_et_i(dbg_saved_et_i),
    .dbg_saved_s_i (dbg_saved_s_i),
    .dbg_mode_i    (dbg_mode_i),
    .dbg_field_i   (dbg_field_i),
    .case_o        (rcase),
    .next_pc_o     (ret_pc),
    .s_o           (ret_s),
    .et_o          (ret_et)
  );

  // next-state
  logic              hold_en, trap_en;
  logic [XLEN-1:0]   pc_d;
  logic              s_d, et_d;
  logic              trap_d, halt_d, ill_d, we_d, dexit_d;

  always_comb begin
    hold_en = start_i;
    trap_en = start_i && !op_ret_i;
    trap_d  = 1'b0;
    halt_d  = 1'b0;
    ill_d   = 1'b0;
    we_d    = 1'b0;
    dexit_d = 1'b0;
    pc_d    = pc_i + STEP;
    s_d     = stat_s_i;
    et_d    = stat_et_i;
    if (start_i) begin
      if (!op_ret_i) begin
        trap_d = 1'b1;
      end else begin
        pc_d    = ret_pc;
        s_d     = ret_s;
        et_d    = ret_et;
        halt_d  = (rcase == RC_HALT_CHK);
        ill_d   = (rcase == RC_ILLEGAL);
        we_d    = (rcase == RC_NORMAL) || (rcase == RC_DEBUG);
        dexit_d = (rcase == RC_DEBUG);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o     <= 1'b0;
      trap_req_o <= 1'b0;
      halt_o     <= 1'b0;
      illegal_o  <= 1'b0;
      stat_we_o  <= 1'b0;
      dbg_exit_o <= 1'b0;
    end else begin
      done_o     <= start_i;
      trap_req_o <= trap_d;
      halt_o     <= halt_d;
      illegal_o  <= ill_d;
      stat_we_o  <= we_d;
      dbg_exit_o <= dexit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pc_o <= '0;
      stat_s_o  <= 1'b0;
      stat_et_o <= 1'b0;
    end else if (hold_en) begin
      next_pc_o <= pc_d;
      stat_s_o  <= s_d;
      stat_et_o <= et_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      trap_num_o <= '0;
    else if (trap_en)
      trap_num_o <= vec_num;
  end
endmodule

// File: rtl/trapret_unit_chk.sv
module trapret_unit_chk #(
  parameter int XLEN   = 32,
  parameter int TNUM_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              op_ret_i,
  input logic [XLEN-1:0]   pc_i,
  input logic              done_o,
  input logic [XLEN-1:0]   next_pc_o,
  input logic [TNUM_W-1:0] trap_num_o,
  input logic              trap_req_o,
  input logic              halt_o,
  input logic              illegal_o,
  input logic              stat_we_o,
  input logic              dbg_exit_o
);
  // R9: done one cycle after start
  a_r9_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);
  a_r9_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);
  // R2/R4: halt and illegal are exclusive
  a_r4_halt_ill_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_o && illegal_o));
  // R2: halt comes with PC+4
  a_r2_halt_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_ret_i) |=> (!halt_o || next_pc_o == $past(pc_i) + XLEN'(4)));
  // R6: leaving debug mode always carries a status write
  a_r6_exit_writes: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_exit_o |-> stat_we_o);
  // R1: trap number upper bit always set after a trap
  a_r1_trap_range: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req_o |-> (trap_num_o[TNUM_W-1] && !stat_we_o && !halt_o));
  // R11: a return leaves the trap number alone
  a_r11_num_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_ret_i) |=> $stable(trap_num_o));
endmodule

bind trapret_unit trapret_unit_chk #(.XLEN(XLEN), .TNUM_W(TNUM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .op_ret_i  (op_ret_i),
  .pc_i      (pc_i),
  .done_o    (done_o),
  .next_pc_o (next_pc_o),
  .trap_num_o(trap_num_o),
  .trap_req_o(trap_req_o),
  .halt_o    (halt_o),
  .illegal_o (illegal_o),
  .stat_we_o (stat_we_o),
  .dbg_exit_o(dbg_exit_o)
);

// File: tb/sim_trapret_unit.sv
module sim_trapret_unit;
  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic        start_i, op_ret_i;
  logic [31:0] base_i, offset_i, pc_i, saved_pc_i, dbg_saved_pc_i;
  logic        stat_s_i, stat_et_i, stat_ps_i, dbg_saved_et_i, dbg_saved_s_i;
  logic        dbg_mode_i, dbg_field_i;
  logic        done_o, trap_req_o, halt_o, illegal_o, stat_we_o, stat_s_o, stat_et_o, dbg_exit_o;
  logic [31:0] next_pc_o;
  logic [7:0]  trap_num_o;

  trapret_unit u0 (.*);

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] last_num;

  // expected values
  logic [31:0] e_pc;
  logic [7:0]  e_num;
  logic e_trap, e_halt, e_ill, e_we, e_s, e_et, e_dx;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model();
    e_trap = 0; e_halt = 0; e_ill = 0; e_we = 0; e_dx = 0;
    e_pc = pc_i + 32'd4; e_s = stat_s_i; e_et = stat_et_i; e_num = last_num;
    if (!op_ret_i) begin
      e_trap = 1;
      e_num  = 8'(((base_i + offset_i) & 32'h7f) + 32'h80);
    end else if (!stat_s_i) begin
      e_halt = !stat_et_i;
    end else if (stat_et_i) begin
      e_ill = 1;
    end else if (!dbg_mode_i && !dbg_field_i) begin
      e_we = 1; e_pc = saved_pc_i; e_et = 1; e_s = stat_ps_i;
    end else if (dbg_mode_i && dbg_field_i) begin
      e_we = 1; e_dx = 1; e_pc = dbg_saved_pc_i; e_et = dbg_saved_et_i; e_s = dbg_saved_s_i;
    end
  endtask

  function automatic string tag();
    if (!op_ret_i) return "R1";
    if (!stat_s_i) return stat_et_i ? "R3" : "R2";
    if (stat_et_i) return "R4";
    if (!dbg_mode_i && !dbg_field_i) return "R5";
    if (dbg_mode_i && dbg_field_i) return "R6";
    return "R7";
  endfunction

  task automatic apply(input string prio);
    string t;
    model();
    t = (prio != "") ? prio : tag();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk("R9", "done", 32'(done_o), 32'd1);
    chk(t, "next_pc", next_pc_o, e_pc);
    chk(t, "trap_req", 32'(trap_req_o), 32'(e_trap));
    chk(t, "halt", 32'(halt_o), 32'(e_halt));
    chk(t, "illegal", 32'(illegal_o), 32'(e_ill));
    chk(t, "stat_we", 32'(stat_we_o), 32'(e_we));
    chk(t, "stat_s", 32'(stat_s_o), 32'(e_s));
    chk(t, "stat_et", 32'(stat_et_o), 32'(e_et));
    chk(t, "dbg_exit", 32'(dbg_exit_o), 32'(e_dx));
    chk(op_ret_i ? "R11" : "R1", "trap_num", 32'(trap_num_o), 32'(e_num));
    last_num = e_num;
  endtask

  task automatic set_ret(input logic s, input logic et, input logic dm, input logic df);
    op_ret_i = 1; stat_s_i = s; stat_et_i = et; dbg_mode_i = dm; dbg_field_i = df;
    pc_i = $urandom; saved_pc_i = $urandom; dbg_saved_pc_i = $urandom;
    stat_ps_i = $urandom; dbg_saved_et_i = $urandom; dbg_saved_s_i = $urandom;
  endtask

  initial begin
    #3000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; start_i = 0; op_ret_i = 0; base_i = 0; offset_i = 0; pc_i = 0;
    saved_pc_i = 0; dbg_saved_pc_i = 0; stat_s_i = 0; stat_et_i = 0; stat_ps_i = 0;
    dbg_saved_et_i = 0; dbg_saved_s_i = 0; dbg_mode_i = 0; dbg_field_i = 0;
    last_num = 8'h00;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "done", 32'(done_o), 0);
    chk("R10", "next_pc", next_pc_o, 0);
    chk("R10", "trap_num", 32'(trap_num_o), 0);
    chk("R10", "pulses", 32'({trap_req_o, halt_o, illegal_o, stat_we_o, dbg_exit_o}), 0);
    chk("R10", "status", 32'({stat_s_o, stat_et_o}), 0);
    rst_n = 1;
    @(negedge clk);

    // R1 directed: wrap of the low bits
    op_ret_i = 0; base_i = 32'hffff_ff80; offset_i = 32'h0000_007f; pc_i = 32'h100; apply("R1");
    op_ret_i = 0; base_i = 32'h7fff_ffff; offset_i = 32'h0000_0001; pc_i = 32'h200; apply("R1");
    // R8 priority: debug-return inputs present but earlier case wins
    set_ret(0, 0, 1, 1); apply("R8");
    set_ret(0, 1, 1, 1); apply("R8");
    set_ret(1, 1, 1, 1); apply("R8");
    set_ret(1, 1, 0, 0); apply("R8");
    // R6 debug return: write and debug exit together
    set_ret(1, 0, 1, 1); apply("R6");
    // R5 normal, R7 mismatches
    set_ret(1, 0, 0, 0); apply("R5");
    set_ret(1, 0, 1, 0); apply("R7");
    set_ret(1, 0, 0, 1); apply("R7");
    // R9 pulses drop without a start
    @(negedge clk);
    chk("R9", "done idle", 32'(done_o), 0);
    chk("R9", "pulses idle", 32'({trap_req_o, halt_o, illegal_o, stat_we_o, dbg_exit_o}), 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        op_ret_i = 0; base_i = $urandom; offset_i = $urandom; pc_i = $urandom;
      end else begin
        set_ret($urandom, $urandom, $urandom, $urandom);
        base_i = $urandom; offset_i = $urandom;
      end
      apply("");
      if ($urandom_range(0, 2) == 0) @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule